// File: doc/BRIEF.md
# Receive Descriptor Fetch and Write-Back Scheduler

This block sits beside a network receive DMA engine and decides when that engine should pull new receive descriptors from host memory and when it should return finished ones. It keeps three counts. The first is the number of unprocessed descriptors held in the on-chip buffer. The second is the number of valid descriptors that software has posted in host memory. The third is the number of completed descriptors waiting to go back to the host. From these counts and one 32-bit control word it raises a fetch request or a write-back request, each with a burst length. Each request is then held until the DMA engine returns a one-cycle acknowledge.

The control word carries three 6-bit thresholds and a unit bit. One threshold sets the on-chip low level, one sets the minimum host backlog for a fetch, and one sets the write-back batch size. When the unit bit is set, the thresholds count 16-byte descriptors. When it is clear, they count 32-byte cache lines, so each threshold is doubled, and any value above 15 lines is treated as 15. A flush input forces out every completed descriptor that is pending, whatever the batch threshold says.

Top module: `rxdesc_sched`

## Requirements
- R1: After reset the control word reads 0x00010000. A write stores only the prefetch level in bits 5:0, the host backlog level in bits 13:8, the batch level in bits 21:16 and the unit bit in bit 24. Every other bit reads as zero, so writing all ones reads back 0x013F3F3F. The word does not change without a write.
- R2: With the unit bit at 1, a threshold compares directly against descriptor counts. With the unit bit at 0, the threshold is first clamped to at most 15 and then doubled, so its effective value is at most 30.
- R3: A fetch request rises only when, in the previous cycle, no fetch was outstanding, the on-chip count was strictly below the effective prefetch level, the host count was at least the effective backlog level, and the burst length was nonzero.
- R4: The fetch burst length is the smaller of the host count and the free buffer space, where free space is DEPTH minus the on-chip count. It lies between 1 and DEPTH.
- R5: At most one fetch is outstanding. The request and its length stay unchanged until an acknowledge arrives. On that acknowledge the on-chip count rises by the length, the host count falls by the length, and the request drops in the following cycle.
- R6: Without a flush, a write-back request rises only when no write-back is outstanding and the completed count is strictly greater than the effective batch level. Its length equals the completed count in the cycle before the request rises.
- R7: A flush while no write-back is outstanding and at least one completed descriptor is pending raises a write-back of all of them at the next edge. A flush with nothing pending raises no request. A flush during an outstanding write-back is held and served after the acknowledge, provided descriptors are still pending then.
- R8: At most one write-back is outstanding. The request and its length stay unchanged until an acknowledge arrives. On that acknowledge the completed count falls by the length.
- R9: A processed pulse moves one descriptor from the on-chip count to the completed count. The pulse is ignored when the on-chip count is 0 or the completed count is DEPTH. A post pulse adds its amount to the host count, saturating at the count's maximum.
- R10: An acknowledge that arrives while no request of its kind is outstanding changes no count and no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read value |
| host_post | input | 1 | Software posted descriptors to host memory |
| host_post_num | input | POST_W (6) | Number of descriptors posted |
| desc_done | input | 1 | Receive engine finished one on-chip descriptor |
| flush | input | 1 | Force write-back of all completed descriptors |
| fetch_req | output | 1 | Fetch request, held until acknowledged |
| fetch_len | output | CW (6) | Fetch burst length in descriptors |
| fetch_ack | input | 1 | Fetch completion pulse |
| wb_req | output | 1 | Write-back request, held until acknowledged |
| wb_len | output | CW (6) | Write-back burst length in descriptors |
| wb_ack | input | 1 | Write-back completion pulse |
| onchip_cnt | output | CW (6) | Unprocessed descriptors on chip |
| host_cnt | output | HOST_W (12) | Valid descriptors in host memory |
| done_cnt | output | CW (6) | Completed descriptors awaiting write-back |

## Verification
The on-chip count can change from two sources in one cycle: a fetch acknowledge adds a burst, and a processed pulse removes one descriptor. The completed count has the same kind of overlap between a processed pulse and a write-back acknowledge. The bench drives acknowledges, processed pulses, posts and flushes from independent random draws, so these overlaps occur many times, including acknowledges with nothing outstanding. A bench model updates every count from the requirements each cycle, and all counts, requests and lengths are compared against it between edges.

// File: rtl/rxdesc_pkg.sv
package rxdesc_pkg;

    localparam int THR_W   = 6;
    localparam int STHR_W  = 7;
    localparam int PF_LSB  = 0;
    localparam int HS_LSB  = 8;
    localparam int WB_LSB  = 16;
    localparam int UNIT_BIT = 24;

    localparam logic [31:0] CFG_RESET = 32'h0001_0000;
    localparam logic [31:0] CFG_MASK  = 32'h013F_3F3F;
    localparam logic [THR_W-1:0] LINE_CAP = 6'd15;

    typedef enum logic {
        REQ_IDLE = 1'b0,
        REQ_WAIT = 1'b1
    } req_st_e;

    typedef struct packed {
        logic [STHR_W-1:0] pf;
        logic [STHR_W-1:0] hs;
        logic [STHR_W-1:0] wb;
    } thr_set_t;

    // Convert a programmed threshold into a descriptor count.
    function automatic logic [STHR_W-1:0] scale_thr(input logic [THR_W-1:0] v,
                                                    input logic unit_desc);
        logic [THR_W-1:0] capped;
        capped = (v > LINE_CAP) ? LINE_CAP : v;
        if (unit_desc)
            return {1'b0, v};
        else
            return {capped, 1'b0};
    endfunction

endpackage

// File: rtl/rxdesc_cfg.sv
module rxdesc_cfg
    import rxdesc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output thr_set_t    thr
);
    logic [31:0] cfg_q;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= CFG_RESET;
        else if (we)
            cfg_q <= wdata & CFG_MASK;
    end

    assign rdata = cfg_q;

    always_comb begin
        thr.pf = scale_thr(cfg_q[PF_LSB +: THR_W], cfg_q[UNIT_BIT]);
        thr.hs = scale_thr(cfg_q[HS_LSB +: THR_W], cfg_q[UNIT_BIT]);
        thr.wb = scale_thr(cfg_q[WB_LSB +: THR_W], cfg_q[UNIT_BIT]);
    end

    // R2: line units never exceed 15 lines
    a_r2_line_cap: assert property (@(posedge clk) disable iff (rst)
        !rdata[UNIT_BIT] |-> (thr.pf <= 7'd30 && thr.hs <= 7'd30 && thr.wb <= 7'd30));

    // R1: word is stable when not written
    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(rdata));

endmodule

// File: rtl/rxdesc_count.sv
module rxdesc_count #(
    parameter int DEPTH  = 32,
    parameter int CW     = 6,
    parameter int HOST_W = 12,
    parameter int POST_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_fin,
    input  logic [CW-1:0]     fetch_len,
    input  logic              wb_fin,
    input  logic [CW-1:0]     wb_len,
    input  logic              desc_done,
    input  logic              host_post,
    input  logic [POST_W-1:0] host_post_num,
    output logic [CW-1:0]     onchip_cnt,
    output logic [HOST_W-1:0] host_cnt,
    output logic [CW-1:0]     done_cnt
);
    localparam logic [CW-1:0]   DEPTH_C  = CW'(DEPTH);
    localparam logic [HOST_W:0] HOST_MAX = {1'b0, {HOST_W{1'b1}}};

    logic [CW-1:0]     on_q, dn_q;
    logic [HOST_W-1:0] hs_q;
    logic              move_ok;
    logic [HOST_W:0]   hs_sum;
    logic [CW-1:0]     on_in, dn_out;

    assign move_ok = desc_done && (on_q != '0) && (dn_q != DEPTH_C);
    assign on_in   = fetch_fin ? fetch_len : '0;
    assign dn_out  = wb_fin ? wb_len : '0;

    always_comb begin
        hs_sum = {1'b0, hs_q};
        if (fetch_fin)
            hs_sum = hs_sum - (HOST_W+1)'(fetch_len);
        if (host_post)
            hs_sum = hs_sum + (HOST_W+1)'(host_post_num);
        if (hs_sum > HOST_MAX)
            hs_sum = HOST_MAX;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q <= '0;
            dn_q <= '0;
            hs_q <= '0;
        end else begin
            on_q <= on_q + on_in - (move_ok ? CW'(1) : CW'(0));
            dn_q <= dn_q - dn_out + (move_ok ? CW'(1) : CW'(0));
            hs_q <= hs_sum[HOST_W-1:0];
        end
    end

    assign onchip_cnt = on_q;
    assign host_cnt   = hs_q;
    assign done_cnt   = dn_q;

    // R9: counts stay inside the buffer
    a_r9_bounds: assert property (@(posedge clk) disable iff (rst)
        (on_q <= DEPTH_C) && (dn_q <= DEPTH_C));

    // R9: an ignored processed pulse keeps the completed count
    a_r9_empty_move: assert property (@(posedge clk) disable iff (rst)
        (desc_done && on_q == '0 && !wb_fin) |=> $stable(dn_q));

endmodule

// File: rtl/rxdesc_fetch.sv
module rxdesc_fetch
    import rxdesc_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int CW     = 6,
    parameter int HOST_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CW-1:0]     onchip_cnt,
    input  logic [HOST_W-1:0] host_cnt,
    input  logic [STHR_W-1:0] pf_lvl,
    input  logic [STHR_W-1:0] hs_lvl,
    input  logic              ack,
    output logic              req,
    output logic [CW-1:0]     len,
    output logic              fin
);
    req_st_e       st_q;
    logic [CW-1:0] len_q;
    logic [CW-1:0] free_sp;
    logic [CW-1:0] burst;
    logic          low_on, host_ok, go;

    assign free_sp = CW'(DEPTH) - onchip_cnt;
    assign burst   = (32'(host_cnt) < 32'(free_sp)) ? CW'(host_cnt) : free_sp;
    assign low_on  = 32'(onchip_cnt) < 32'(pf_lvl);
    assign host_ok = 32'(host_cnt) >= 32'(hs_lvl);
    assign go      = (st_q == REQ_IDLE) && low_on && host_ok && (burst != '0);
    assign fin     = (st_q == REQ_WAIT) && ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= REQ_IDLE;
            len_q <= '0;
        end else if (fin) begin
            st_q  <= REQ_IDLE;
        end else if (go) begin
            st_q  <= REQ_WAIT;
            len_q <= burst;
        end
    end

    assign req = (st_q == REQ_WAIT);
    assign len = len_q;

    // R5: request and length held until acknowledged
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (req && !ack) |=> (req && $stable(len)));

    // R4: burst length in range
    a_r4_len_range: assert property (@(posedge clk) disable iff (rst)
        req |-> (len != '0 && 32'(len) <= DEPTH));

    // R3: both thresholds met before a request rises
    a_r3_gate: assert property (@(posedge clk) disable iff (rst)
        $rose(req) |-> $past(low_on && host_ok));

    // R5: acknowledge drops the request
    a_r5_drop: assert property (@(posedge clk) disable iff (rst)
        (req && ack) |=> !req);

endmodule

// File: rtl/rxdesc_wb.sv
module rxdesc_wb
    import rxdesc_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CW-1:0]     done_cnt,
    input  logic [STHR_W-1:0] wb_lvl,
    input  logic              flush,
    input  logic              ack,
    output logic              req,
    output logic [CW-1:0]     len,
    output logic              fin
);
    req_st_e       st_q;
    logic [CW-1:0] len_q;
    logic          pend_q;
    logic          over, go;

    assign over = 32'(done_cnt) > 32'(wb_lvl);
    assign go   = (st_q == REQ_IDLE) && (done_cnt != '0) && (over || flush || pend_q);
    assign fin  = (st_q == REQ_WAIT) && ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= REQ_IDLE;
            len_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (fin) begin
                st_q <= REQ_IDLE;
            end else if (go) begin
                st_q  <= REQ_WAIT;
                len_q <= done_cnt;
            end
            if (go)
                pend_q <= 1'b0;
            else if (st_q == REQ_WAIT)
                pend_q <= pend_q | flush;
            else
                pend_q <= 1'b0;
        end
    end

    assign req = (st_q == REQ_WAIT);
    assign len = len_q;

    // R8: request and length held until acknowledged
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (req && !ack) |=> (req && $stable(len)));

    // R6: length equals the pending count when issued
    a_r6_len: assert property (@(posedge clk) disable iff (rst)
        $rose(req) |-> (len == $past(done_cnt) && len != '0));

    // R7: flush with pending work and no outstanding request issues at once
    a_r7_flush: assert property (@(posedge clk) disable iff (rst)
        (flush && !req && done_cnt != '0) |=> req);

    // R7: flush with nothing pending and idle issues nothing
    a_r7_empty: assert property (@(posedge clk) disable iff (rst)
        (!req && done_cnt == '0) |=> !req);

endmodule

// File: rtl/rxdesc_sched.sv
module rxdesc_sched
    import rxdesc_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int HOST_W = 12,
    parameter int POST_W = 6,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              host_post,
    input  logic [POST_W-1:0] host_post_num,
    input  logic              desc_done,
    input  logic              flush,
    output logic              fetch_req,
    output logic [CW-1:0]     fetch_len,
    input  logic              fetch_ack,
    output logic              wb_req,
    output logic [CW-1:0]     wb_len,
    input  logic              wb_ack,
    output logic [CW-1:0]     onchip_cnt,
    output logic [HOST_W-1:0] host_cnt,
    output logic [CW-1:0]     done_cnt
);
    thr_set_t thr;
    logic     f_fin, w_fin;

    rxdesc_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .thr   (thr)
    );

    rxdesc_count #(
        .DEPTH  (DEPTH),
        .CW     (CW),
        .HOST_W (HOST_W),
        .POST_W (POST_W)
    ) u_count (
        .clk           (clk),
        .rst           (rst),
        .fetch_fin     (f_fin),
        .fetch_len     (fetch_len),
        .wb_fin        (w_fin),
        .wb_len        (wb_len),
        .desc_done     (desc_done),
        .host_post     (host_post),
        .host_post_num (host_post_num),
        .onchip_cnt    (onchip_cnt),
        .host_cnt      (host_cnt),
        .done_cnt      (done_cnt)
    );

    rxdesc_fetch #(
        .DEPTH  (DEPTH),
        .CW     (CW),
        .HOST_W (HOST_W)
    ) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .onchip_cnt (onchip_cnt),
        .host_cnt   (host_cnt),
        .pf_lvl     (thr.pf),
        .hs_lvl     (thr.hs),
        .ack        (fetch_ack),
        .req        (fetch_req),
        .len        (fetch_len),
        .fin        (f_fin)
    );

    rxdesc_wb #(
        .CW (CW)
    ) u_wb (
        .clk      (clk),
        .rst      (rst),
        .done_cnt (done_cnt),
        .wb_lvl   (thr.wb),
        .flush    (flush),
        .ack      (wb_ack),
        .req      (wb_req),
        .len      (wb_len),
        .fin      (w_fin)
    );

    // R10: a stray fetch acknowledge leaves the host count alone
    a_r10_stray: assert property (@(posedge clk) disable iff (rst)
        (fetch_ack && !fetch_req && !host_post) |=> $stable(host_cnt));

endmodule

// File: tb/rxdesc_sched_test.sv
module rxdesc_sched_test;
    localparam int DEPTH = 32;
    localparam int CW = 6;
    localparam int HMAX = 4095;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        host_post = 1'b0;
    logic [5:0]  host_post_num = '0;
    logic        desc_done = 1'b0;
    logic        flush = 1'b0;
    logic        fetch_req, wb_req;
    logic [CW-1:0] fetch_len, wb_len, onchip_cnt, done_cnt;
    logic        fetch_ack = 1'b0, wb_ack = 1'b0;
    logic [11:0] host_cnt;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // bench model state
    logic [31:0] m_cfg;
    int m_on, m_host, m_done, m_flen, m_wlen;
    bit m_fb, m_wb, m_fp;

    always #10 clk = ~clk;

    rxdesc_sched uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .host_post(host_post), .host_post_num(host_post_num),
        .desc_done(desc_done), .flush(flush), .fetch_req(fetch_req),
        .fetch_len(fetch_len), .fetch_ack(fetch_ack), .wb_req(wb_req),
        .wb_len(wb_len), .wb_ack(wb_ack), .onchip_cnt(onchip_cnt),
        .host_cnt(host_cnt), .done_cnt(done_cnt)
    );

    function automatic int scl(input logic [5:0] v, input logic unit);
        int c;
        c = (int'(v) > 15) ? 15 : int'(v);
        return unit ? int'(v) : 2 * c;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R1 cfg_rdata", int'(cfg_rdata), int'(m_cfg));
        chk("R3 fetch_req", int'(fetch_req), int'(m_fb));
        if (m_fb) chk("R4 fetch_len", int'(fetch_len), m_flen);
        chk("R6 wb_req", int'(wb_req), int'(m_wb));
        if (m_wb) chk("R6 wb_len", int'(wb_len), m_wlen);
        chk("R5 onchip_cnt", int'(onchip_cnt), m_on);
        chk("R9 host_cnt", int'(host_cnt), m_host);
        chk("R8 done_cnt", int'(done_cnt), m_done);
    endtask

    // one clock: advance model from current inputs, then compare at negedge
    task automatic step();
        int pf, hs, wbt, burst, n_on, n_host, n_done;
        bit f_ok, w_ok, mv, fgo, wgo;
        pf  = scl(m_cfg[5:0], m_cfg[24]);
        hs  = scl(m_cfg[13:8], m_cfg[24]);
        wbt = scl(m_cfg[21:16], m_cfg[24]);
        f_ok = fetch_ack && m_fb;
        w_ok = wb_ack && m_wb;
        mv = desc_done && m_on != 0 && m_done != DEPTH;
        burst = (m_host < DEPTH - m_on) ? m_host : DEPTH - m_on;
        fgo = !m_fb && m_on < pf && m_host >= hs && burst != 0;
        wgo = !m_wb && m_done != 0 && (m_done > wbt || flush || m_fp);
        n_on = m_on + (f_ok ? m_flen : 0) - (mv ? 1 : 0);
        n_host = m_host - (f_ok ? m_flen : 0) + (host_post ? int'(host_post_num) : 0);
        if (n_host > HMAX) n_host = HMAX;
        n_done = m_done - (w_ok ? m_wlen : 0) + (mv ? 1 : 0);
        if (f_ok) m_fb = 0;
        else if (fgo) begin m_fb = 1; m_flen = burst; end
        if (w_ok) m_wb = 0;
        else if (wgo) begin m_wb = 1; m_wlen = m_done; end
        if (wgo) m_fp = 0;
        else if (!w_ok && !m_wb) m_fp = 0;
        else if (m_wb || w_ok) m_fp = m_fp | flush;
        if (cfg_we) m_cfg = cfg_wdata & 32'h013F_3F3F;
        m_on = n_on; m_host = n_host; m_done = n_done;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle_in();
        cfg_we = 0; host_post = 0; host_post_num = '0; desc_done = 0;
        flush = 0; fetch_ack = 0; wb_ack = 0;
    endtask

    task automatic wcfg(input logic [31:0] v);
        idle_in(); cfg_we = 1; cfg_wdata = v; step(); idle_in();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        m_cfg = 32'h0001_0000; m_on = 0; m_host = 0; m_done = 0;
        m_flen = 0; m_wlen = 0; m_fb = 0; m_wb = 0; m_fp = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 reset value", int'(cfg_rdata), 32'h0001_0000);
        compare_all();
        rst = 1'b0;

        // R1 reserved bits read zero
        wcfg(32'hFFFF_FFFF);
        chk("R1 mask readback", int'(cfg_rdata), 32'h013F_3F3F);

        // R3 host backlog too small: descriptor units, pf=4, hs=6, wb=1
        wcfg(32'h0101_0604);
        host_post = 1; host_post_num = 6'd5; step(); idle_in();
        repeat (3) step();
        chk("R3 no fetch with small backlog", int'(fetch_req), 0);
        host_post = 1; host_post_num = 6'd1; step(); idle_in();
        step();
        chk("R4 burst is host backlog", int'(fetch_len), 6);
        // R7 flush with nothing pending
        flush = 1; step(); idle_in(); step();
        chk("R7 empty flush no request", int'(wb_req), 0);
        // R10 stray write-back acknowledge
        wb_ack = 1; step(); idle_in();
        fetch_ack = 1; step(); idle_in();
        chk("R5 onchip after ack", int'(onchip_cnt), 6);

        // R2 line units with clamp: pf=40 -> 30, hs=0, wb=63 -> 30
        wcfg(32'h003F_0028);
        host_post = 1; host_post_num = 6'd63; step(); idle_in();
        repeat (2) step();
        // R7 flush forces write-back below batch level
        desc_done = 1; step(); step(); idle_in();
        flush = 1; step(); idle_in();
        chk("R7 flush raises request", int'(wb_req), 1);
        chk("R7 flush length", int'(wb_len), 2);
        wb_ack = 1; fetch_ack = 1; step(); idle_in();

        // random phase
        for (int i = 0; i < 6000; i++) begin
            idle_in();
            if ($urandom_range(0, 99) < 3) begin
                cfg_we = 1;
                cfg_wdata = $urandom();
                if ($urandom_range(0, 1) == 1) cfg_wdata[13:8] = 6'($urandom_range(0, 4));
                if ($urandom_range(0, 1) == 1) cfg_wdata[21:16] = 6'($urandom_range(0, 5));
            end
            if ($urandom_range(0, 99) < 12) begin
                host_post = 1;
                host_post_num = 6'($urandom_range(0, 63));
            end
            desc_done = ($urandom_range(0, 99) < 45);
            flush     = ($urandom_range(0, 99) < 5);
            fetch_ack = ($urandom_range(0, 99) < 30);
            wb_ack    = ($urandom_range(0, 99) < 30);
            step();
        end
        idle_in();
        step();

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule